// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block supervises software liveness with a free-running counter that starts as soon as reset is released. When the counter runs out the first time, a warning flag goes high so that software still has one full period to react. If the counter runs out again while the warning is still pending, the block raises a one-clock system reset request for an external reset controller. A service strobe restarts the period and withdraws the warning.

Turning the watchdog off is deliberately awkward. A disable strobe only arms a one-cycle window, and the block turns off only if a service strobe arrives in the very next cycle. Once off, only a system reset turns it back on. A low-power entry signal clears both the counter and the warning, so that the time spent entering retention is not charged to the running period.

Top module: `wdog_twostage`

## Requirements
- R1: While reset is asserted and right after its release, en_o is 1, warn_o is 0 and rst_req_o is 0. The counter starts from zero.
- R2: With the watchdog enabled and no service or low-power input, warn_o rises on the 2^CNT_W-th rising clock edge after the counter last restarted. It is still 0 one edge earlier.
- R3: If the counter expires a second time while warn_o is 1, rst_req_o is 1 for exactly one clock, 2^CNT_W edges after the warning was set. warn_o stays 1 during that clock.
- R4: A service strobe (svc_i high at a rising edge) sets the counter to zero and clears warn_o at that edge.
- R5: A disable strobe (dis_i high at an edge) followed at the very next edge by svc_i high, with dis_i low, clears en_o at that second edge. From then on the counter is frozen, and warn_o and rst_req_o stay 0.
- R6: A disable strobe whose next edge does not carry a service strobe is discarded, and en_o stays 1. This includes dis_i and svc_i high in the same cycle followed by an idle cycle.
- R7: A service strobe followed by a disable strobe (the reverse order) does not clear en_o.
- R8: lp_enter_i high at an edge sets the counter to zero and clears warn_o.
- R9: Once en_o is 0, further service or disable strobes leave it at 0. Only a system reset sets it to 1 again.
- R10: A service or low-power input in the same cycle as a terminal count takes precedence. No warning or reset request is produced, and a full new period starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running count clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| svc_i | input | 1 | Service strobe: restarts the period and clears the warning |
| dis_i | input | 1 | Disable strobe: arms a one-cycle disable window |
| lp_enter_i | input | 1 | Low-power entry: clears the counter and the warning |
| warn_o | output | 1 | First-stage timeout warning |
| en_o | output | 1 | Watchdog enabled flag |
| rst_req_o | output | 1 | Registered one-clock system reset request |

## Verification
The bench probes both sides of each terminal count, one edge before and at the expiry. A counter that is one too short or too long, or a reset request that lasts two cycles, is caught there. It tries the disable sequence in every wrong form: disable alone, disable and service together, and service before disable. A guard that latched the disable or ignored the order would switch the watchdog off in those cases. It places service and low-power inputs exactly on the terminal cycle and then measures a full clean period afterwards. A design that let the count win, or only cleared the flag and not the counter, would warn early or request a reset. Finally it checks that strobes never re-enable a disabled watchdog and that reset does.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // What the period counter does on the next edge
  typedef enum logic [1:0] {
    CA_HOLD  = 2'd0,
    CA_STEP  = 2'd1,
    CA_WRAP  = 2'd2,
    CA_CLEAR = 2'd3
  } cnt_act_e;

  // Priority: clear (service / low power) beats everything, then a stopped
  // counter holds, then a counter at its top value wraps, else it steps.
  function automatic cnt_act_e next_action(input logic run, input logic clr,
                                           input logic at_top);
    if (clr)         return CA_CLEAR;
    else if (!run)   return CA_HOLD;
    else if (at_top) return CA_WRAP;
    else             return CA_STEP;
  endfunction

  // Second-stage decision: a wrap with the warning already pending
  function automatic logic escalate(input logic wrap, input logic warned);
    return wrap & warned;
  endfunction

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic term_o
);

  localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             at_top;
  cnt_act_e         act;

  assign at_top = (cnt_q == TOP_VAL);
  assign act    = next_action(run_i, clr_i, at_top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case (act)
        CA_CLEAR, CA_WRAP: cnt_q <= '0;
        CA_STEP:           cnt_q <= cnt_q + 1'b1;
        default:           cnt_q <= cnt_q;
      endcase
    end
  end

  assign term_o = (act == CA_WRAP);

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_i,
  input  logic svc_i,
  output logic en_o,
  output logic fire_o
);

  logic arm_q;
  logic en_q;

  // The disable only completes when the edge right after the disable strobe
  // carries a lone service strobe.
  assign fire_o = arm_q & svc_i & ~dis_i & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      en_q  <= 1'b1;
    end else begin
      arm_q <= dis_i & en_q;
      if (fire_o) en_q <= 1'b0;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/wdog_stages.sv
module wdog_stages
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic term_i,
  input  logic clr_i,
  output logic warn_o,
  output logic req_o
);

  logic warn_q;
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= escalate(term_i, warn_q) & ~clr_i;
      if (clr_i)       warn_q <= 1'b0;
      else if (term_i) warn_q <= 1'b1;
    end
  end

  assign warn_o = warn_q;
  assign req_o  = req_q;

endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic svc_i,
  input  logic dis_i,
  input  logic lp_enter_i,
  output logic warn_o,
  output logic en_o,
  output logic rst_req_o
);

  logic cnt_clr;
  logic term_hit;
  logic dis_fire;
  logic en_w;

  assign cnt_clr = svc_i | lp_enter_i;

  wdog_guard u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .dis_i  (dis_i),
    .svc_i  (svc_i),
    .en_o   (en_w),
    .fire_o (dis_fire)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (en_w),
    .clr_i  (cnt_clr),
    .term_o (term_hit)
  );

  wdog_stages u_stg (
    .clk    (clk),
    .rst_n  (rst_n),
    .term_i (term_hit),
    .clr_i  (cnt_clr),
    .warn_o (warn_o),
    .req_o  (rst_req_o)
  );

  assign en_o = en_w;

endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk (
  input logic clk,
  input logic rst_n,
  input logic svc_i,
  input logic dis_i,
  input logic lp_enter_i,
  input logic warn_o,
  input logic en_o,
  input logic rst_req_o,
  input logic term_hit,
  input logic dis_fire
);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o); // R3
  AST_REQ_NEEDS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> warn_o); // R3
  AST_WARN_FROM_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_o) |-> $past(term_hit)); // R2
  AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    svc_i |=> (!warn_o && !rst_req_o)); // R4
  AST_LP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lp_enter_i |=> !warn_o); // R8
  AST_FIRE_NEEDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    dis_fire |-> (svc_i && $past(dis_i))); // R5
  AST_EN_FALL_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_o) |-> $past(dis_fire)); // R6
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> (!warn_o && !rst_req_o)); // R5
  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |=> !en_o); // R9

endmodule

bind wdog_twostage wdog_twostage_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .svc_i      (svc_i),
  .dis_i      (dis_i),
  .lp_enter_i (lp_enter_i),
  .warn_o     (warn_o),
  .en_o       (en_o),
  .rst_req_o  (rst_req_o),
  .term_hit   (term_hit),
  .dis_fire   (dis_fire)
);

// File: tb/wdog_twostage_bench.sv
`timescale 1ns/1ps
module wdog_twostage_bench;

  localparam int CNT_W = 6;
  localparam int PER   = 1 << CNT_W;   // edges per period

  // cmd: 0 idle, 1 service, 2 disable, 3 low-power
  typedef struct packed {
    logic [1:0]  cmd;
    logic [15:0] gap;
    logic        ew;
    logic        een;
    logic        eq;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 16'd0,   1'b0, 1'b1, 1'b0, 4'd4},  // R4 service from start
    '{2'd0, 16'd61,  1'b0, 1'b1, 1'b0, 4'd2},  // R2 count 62
    '{2'd0, 16'd0,   1'b0, 1'b1, 1'b0, 4'd2},  // R2 count 63, one short
    '{2'd0, 16'd0,   1'b1, 1'b1, 1'b0, 4'd2},  // R2 expiry sets warning
    '{2'd0, 16'd62,  1'b1, 1'b1, 1'b0, 4'd3},  // R3 one short of second expiry
    '{2'd0, 16'd0,   1'b1, 1'b1, 1'b1, 4'd3},  // R3 reset request
    '{2'd0, 16'd0,   1'b1, 1'b1, 1'b0, 4'd3},  // R3 request lasted one clock
    '{2'd1, 16'd0,   1'b0, 1'b1, 1'b0, 4'd4},  // R4 service clears warning
    '{2'd0, 16'd63,  1'b1, 1'b1, 1'b0, 4'd2},  // R2 full period after service
    '{2'd0, 16'd9,   1'b1, 1'b1, 1'b0, 4'd8},  // R8 count 10
    '{2'd3, 16'd0,   1'b0, 1'b1, 1'b0, 4'd8},  // R8 low power clears warning
    '{2'd0, 16'd62,  1'b0, 1'b1, 1'b0, 4'd8},  // R8 counter restarted
    '{2'd0, 16'd0,   1'b1, 1'b1, 1'b0, 4'd8},  // R8 full period after low power
    '{2'd2, 16'd0,   1'b1, 1'b1, 1'b0, 4'd6},  // R6 disable alone
    '{2'd0, 16'd0,   1'b1, 1'b1, 1'b0, 4'd6},  // R6 discarded
    '{2'd2, 16'd0,   1'b1, 1'b1, 1'b0, 4'd5},  // R5 disable
    '{2'd1, 16'd0,   1'b0, 1'b0, 1'b0, 4'd5},  // R5 then service -> off
    '{2'd0, 16'd200, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 stays quiet
    '{2'd1, 16'd0,   1'b0, 1'b0, 1'b0, 4'd9},  // R9 service no re-enable
    '{2'd2, 16'd0,   1'b0, 1'b0, 1'b0, 4'd9},  // R9
    '{2'd1, 16'd0,   1'b0, 1'b0, 1'b0, 4'd9}   // R9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic svc_i = 1'b0;
  logic dis_i = 1'b0;
  logic lp_enter_i = 1'b0;
  logic warn_o, en_o, rst_req_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_twostage #(.CNT_W(CNT_W)) u_wdog_twostage (
    .clk(clk), .rst_n(rst_n), .svc_i(svc_i), .dis_i(dis_i),
    .lp_enter_i(lp_enter_i), .warn_o(warn_o), .en_o(en_o),
    .rst_req_o(rst_req_o)
  );

  task automatic chk(input string tag, input logic ew, input logic een,
                     input logic eq);
    checks++;
    if (warn_o !== ew || en_o !== een || rst_req_o !== eq) begin
      failures++;
      $display("FAIL %s: warn/en/req actual=%b%b%b expected=%b%b%b",
               tag, warn_o, en_o, rst_req_o, ew, een, eq);
    end
  endtask

  task automatic drive(input logic [1:0] cmd);
    svc_i      = (cmd == 2'd1);
    dis_i      = (cmd == 2'd2);
    lp_enter_i = (cmd == 2'd3);
  endtask

  // apply for one edge, then idle for gap edges; ends on a falling edge
  task automatic step(input logic [1:0] cmd, input int gap);
    drive(cmd);
    @(negedge clk);
    drive(2'd0);
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive(2'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    chk("R1 in reset", 1'b0, 1'b1, 1'b0);
    do_reset();
    chk("R1 after release", 1'b0, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].cmd, int'(VECS[i].gap));
      chk($sformatf("R%0d vector %0d", VECS[i].rq, i),
          VECS[i].ew, VECS[i].een, VECS[i].eq);
    end

    // R9 reset re-enables
    do_reset();
    chk("R9 reset re-enables", 1'b0, 1'b1, 1'b0);

    // R10 service on the terminal cycle
    step(2'd0, PER - 2);               // counter at top
    step(2'd1, 0);
    chk("R10 service beats expiry", 1'b0, 1'b1, 1'b0);
    step(2'd0, PER - 2);
    chk("R10 new period one short", 1'b0, 1'b1, 1'b0);
    step(2'd0, 0);
    chk("R10 new period expires", 1'b1, 1'b1, 1'b0);
    // R10 low power on the second terminal cycle
    step(2'd0, PER - 2);
    step(2'd3, 0);
    chk("R10 low power beats escalation", 1'b0, 1'b1, 1'b0);
    step(2'd0, 0);
    chk("R10 no late request", 1'b0, 1'b1, 1'b0);

    // R6 disable and service together, then idle
    do_reset();
    svc_i = 1'b1; dis_i = 1'b1;
    @(negedge clk);
    drive(2'd0);
    step(2'd0, 0);
    chk("R6 simultaneous disable discarded", 1'b0, 1'b1, 1'b0);

    // R7 service then disable, then idle
    step(2'd1, 0);
    step(2'd2, 0);
    step(2'd0, 2);
    chk("R7 reverse order keeps enable", 1'b0, 1'b1, 1'b0);

    // R5 still works after the failed attempts
    step(2'd2, 0);
    step(2'd1, 0);
    chk("R5 proper sequence disables", 1'b0, 1'b0, 1'b0);
    step(2'd0, 3 * PER);
    chk("R5 no timeout while off", 1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule